// File: doc/BRIEF.md
# Protected Clock Control Register Unit

This unit holds two byte-wide clock configuration registers and a main-clock divider. The system control register carries the stop-mode request, the PLL-versus-main clock select, the oscillator drive-strength select and a two-bit main clock division code. The oscillator control register carries a frequency code and a post-divider code. Both registers are written over a simple byte port (write strobe, one-bit register select, eight data bits). A write is accepted only while the protect-enable input is high.

Several side inputs restrict what a write can change. A clock-modification lock freezes the stop and PLL bits. A watchdog lock freezes the stop bit. The stop bit is never allowed to rise while the PLL is selected or while oscillation-stop detection is enabled. Entering stop always forces high drive strength. The oscillator register refuses reserved codes field by field and flags the refusal with a one-cycle error pulse.

The divided main clock leaves the block as a one-cycle enable pulse, not as a gated clock. A new division ratio is adopted only at the divider's terminal count, and the divider freezes while stop is requested.

Top module: `clkctl_unit`

## Requirements
- R1: After reset the system register reads 0x20 (only bit 5, drive high, set) and the oscillator register reads 0x05 (frequency code 01, post-divider code 01). The error pulse is low.
- R2: A write (wr_en=1) changes neither register while prot_en is 0. The target register is chosen by wr_sel, where 0 is the system register and 1 is the oscillator register.
- R3: The system register division code in bits 7:6 selects the spacing of main_tick pulses: code 00 gives one pulse per cycle, 01 one every 2 cycles, 10 one every 4 and 11 one every 16.
- R4: While div_bypass is 1, the division code is ignored and the divider counts at ratio 1.
- R5: While mod_lock is 1, a write leaves system register bits 0 (stop) and 1 (PLL select) unchanged. The other fields are still written.
- R6: While wdt_osc_lock is 1, a write leaves the stop bit (bit 0) unchanged.
- R7: The stop bit never rises in a write whose resulting PLL bit is 1 or while osc_det_en is 1. Such a write keeps the old stop value and still updates the other fields.
- R8: Whenever the stop bit is 1, the drive bit (bit 5) is 1. A write that results in stop=1 forces bit 5 high whatever the data says.
- R9: In the oscillator register, frequency code 10 (bits 1:0) and post-divider code 00 (bits 3:2) are reserved. An accepted write carrying a reserved code keeps that field's old value, still updates the other field, and raises wr_err for exactly the cycle after the write edge.
- R10: A change of division ratio (code or bypass) takes effect only at the divider's terminal count. The pulse that ends the current period comes at the old spacing.
- R11: While the stop bit is 1, main_tick stays low and the divider count is held. Counting resumes from the held count when stop clears.
- R12: Reserved bits read as 0: system bits 4:2 and oscillator bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Register select: 0 system, 1 oscillator |
| wr_data | input | 8 | Write data byte |
| prot_en | input | 1 | Protect-enable: writes accepted only when 1 |
| div_bypass | input | 1 | When 1, main division code has no effect |
| mod_lock | input | 1 | Clock-modification lock (stop and PLL bits) |
| wdt_osc_lock | input | 1 | Watchdog lock (stop bit) |
| osc_det_en | input | 1 | Oscillation-stop detection enabled |
| sys_reg | output | 8 | System control register contents |
| osc_reg | output | 8 | Oscillator control register contents |
| stop_req | output | 1 | Stop-mode request (system bit 0) |
| pll_sel | output | 1 | PLL clock selected (system bit 1) |
| drive_hi | output | 1 | High drive strength (system bit 5) |
| main_tick | output | 1 | One-cycle divided main clock enable |
| wr_err | output | 1 | One-cycle pulse on a refused reserved code |

## Verification
The bench builds the unit with its default parameters: reset values 0x20 and 0x05 and a largest main ratio of 16. This keeps the longest divider period short enough that every ratio, and every ratio change in the middle of a period, is crossed many times within a few thousand cycles. Directed phases walk each division code, the bypass input, each lock, the blocked stop entry under PLL select and under detection, and both reserved oscillator codes. A long random phase then mixes locks, protect and stop entry and exit against the cycle-level model.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned MAX_RATIO = 16;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

  // system register bit positions
  localparam int unsigned SYS_STOP = 0;
  localparam int unsigned SYS_PLL  = 1;
  localparam int unsigned SYS_DRV  = 5;

  localparam logic [1:0] FREQ_RSVD = 2'b10;
  localparam logic [1:0] PDIV_RSVD = 2'b00;

  // terminal count (ratio minus one) for a main division code
  function automatic logic [CNT_W-1:0] main_div_limit(input logic [1:0] code,
                                                      input logic bypass);
    logic [CNT_W-1:0] lim;
    if (bypass) lim = '0;
    else begin
      unique case (code)
        2'b00:   lim = CNT_W'(0);
        2'b01:   lim = CNT_W'(1);
        2'b10:   lim = CNT_W'(3);
        default: lim = CNT_W'(MAX_RATIO - 1);
      endcase
    end
    return lim;
  endfunction

  function automatic logic freq_code_ok(input logic [1:0] code);
    return code != FREQ_RSVD;
  endfunction

  function automatic logic pdiv_code_ok(input logic [1:0] code);
    return code != PDIV_RSVD;
  endfunction
endpackage

// File: rtl/clkctl_sysreg.sv
module clkctl_sysreg
  import clkctl_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wr_data,
  input  logic       mod_lock,
  input  logic       wdt_osc_lock,
  input  logic       osc_det_en,
  output logic [7:0] reg_q
);
  logic pll_nx, stop_cand, stop_unsafe, stop_nx, drv_nx;
  logic [7:0] reg_nx;

  always_comb begin
    pll_nx      = mod_lock ? reg_q[SYS_PLL] : wr_data[SYS_PLL];
    stop_cand   = (mod_lock | wdt_osc_lock) ? reg_q[SYS_STOP] : wr_data[SYS_STOP];
    stop_unsafe = stop_cand & (pll_nx | osc_det_en);
    stop_nx     = stop_unsafe ? reg_q[SYS_STOP] : stop_cand;
    drv_nx      = wr_data[SYS_DRV] | stop_nx;
    reg_nx      = {wr_data[7:6], drv_nx, 3'b000, pll_nx, stop_nx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_q <= RST_VAL;
    else if (wr_hit) reg_q <= reg_nx;
  end

  // R2
  sys_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(reg_q));
  // R5
  sys_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_lock |=> $stable(reg_q[1:0]));
  // R6
  sys_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_osc_lock |=> $stable(reg_q[SYS_STOP]));
  // R7
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_q[SYS_STOP]) |-> (!reg_q[SYS_PLL] && !$past(osc_det_en)));
  // R8
  stop_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[SYS_STOP] |-> reg_q[SYS_DRV]);
  // R12
  sys_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[4:2] == 3'b000);
endmodule

// File: rtl/clkctl_oscreg.sv
module clkctl_oscreg
  import clkctl_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wr_data,
  output logic [7:0] reg_q,
  output logic       err_q
);
  logic       freq_ok, pdiv_ok;
  logic [1:0] freq_nx, pdiv_nx;

  always_comb begin
    freq_ok = freq_code_ok(wr_data[1:0]);
    pdiv_ok = pdiv_code_ok(wr_data[3:2]);
    freq_nx = freq_ok ? wr_data[1:0] : reg_q[1:0];
    pdiv_nx = pdiv_ok ? wr_data[3:2] : reg_q[3:2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= RST_VAL;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_hit & ~(freq_ok & pdiv_ok);
      if (wr_hit) reg_q <= {4'b0000, pdiv_nx, freq_nx};
    end
  end

  // R9
  osc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[1:0] != FREQ_RSVD) && (reg_q[3:2] != PDIV_RSVD));
  // R9
  osc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(wr_hit));
  // R12
  osc_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[7:4] == 4'b0000);
endmodule

// File: rtl/clkctl_divider.sv
module clkctl_divider
  import clkctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_code,
  input  logic       bypass,
  input  logic       halt,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q, lim_q, lim_target;
  logic             term;

  assign lim_target = main_div_limit(div_code, bypass);
  assign term       = (cnt_q == lim_q);
  assign tick       = term & ~halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (!halt) begin
      if (term) begin
        cnt_q <= '0;
        lim_q <= lim_target;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R10
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(lim_q));
  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(cnt_q) && $stable(lim_q)));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
endmodule

// File: rtl/clkctl_unit.sv
module clkctl_unit
  import clkctl_pkg::*;
#(
  parameter logic [7:0] SYS_RST = 8'h20,
  parameter logic [7:0] OSC_RST = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       prot_en,
  input  logic       div_bypass,
  input  logic       mod_lock,
  input  logic       wdt_osc_lock,
  input  logic       osc_det_en,
  output logic [7:0] sys_reg,
  output logic [7:0] osc_reg,
  output logic       stop_req,
  output logic       pll_sel,
  output logic       drive_hi,
  output logic       main_tick,
  output logic       wr_err
);
  logic wr_ok, sys_hit, osc_hit;

  assign wr_ok   = wr_en & prot_en;
  assign sys_hit = wr_ok & ~wr_sel;
  assign osc_hit = wr_ok & wr_sel;

  clkctl_sysreg #(.RST_VAL(SYS_RST)) u_sys (
    .clk(clk), .rst_n(rst_n), .wr_hit(sys_hit), .wr_data(wr_data),
    .mod_lock(mod_lock), .wdt_osc_lock(wdt_osc_lock), .osc_det_en(osc_det_en),
    .reg_q(sys_reg)
  );

  clkctl_oscreg #(.RST_VAL(OSC_RST)) u_osc (
    .clk(clk), .rst_n(rst_n), .wr_hit(osc_hit), .wr_data(wr_data),
    .reg_q(osc_reg), .err_q(wr_err)
  );

  assign stop_req = sys_reg[SYS_STOP];
  assign pll_sel  = sys_reg[SYS_PLL];
  assign drive_hi = sys_reg[SYS_DRV];

  clkctl_divider u_div (
    .clk(clk), .rst_n(rst_n), .div_code(sys_reg[7:6]), .bypass(div_bypass),
    .halt(stop_req), .tick(main_tick)
  );

  // R2
  top_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> ($stable(sys_reg) && $stable(osc_reg) && !wr_err));
  // R11
  stop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !main_tick);
endmodule

// File: tb/clkctl_unit_tb.sv
module clkctl_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, prot_en = 0, div_bypass = 0;
  logic mod_lock = 0, wdt_osc_lock = 0, osc_det_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sys_reg, osc_reg;
  logic stop_req, pll_sel, drive_hi, main_tick, wr_err;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  clkctl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .prot_en(prot_en), .div_bypass(div_bypass), .mod_lock(mod_lock),
    .wdt_osc_lock(wdt_osc_lock), .osc_det_en(osc_det_en),
    .sys_reg(sys_reg), .osc_reg(osc_reg), .stop_req(stop_req), .pll_sel(pll_sel),
    .drive_hi(drive_hi), .main_tick(main_tick), .wr_err(wr_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference state
  int m_sys = 'h20, m_osc = 'h05, m_err = 0, m_cnt = 0, m_per = 1;

  function automatic int period_of(input int code, input logic byp);
    if (byp) return 1;
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 16;
    endcase
  endfunction

  always begin
    @(posedge clk);
    cyc++;
    if (!rst_n) begin
      m_sys = 'h20; m_osc = 'h05; m_err = 0; m_cnt = 0; m_per = 1;
    end else begin
      int stop, pll, d, np, ns, cand, f, pd, nxt_per;
      stop = m_sys & 1; pll = (m_sys >> 1) & 1; d = int'(wr_data);
      nxt_per = period_of((m_sys >> 6) & 3, div_bypass);
      // R3 R4 R10 R11 divider reference
      if (stop == 0) begin
        if (m_cnt + 1 >= m_per) begin m_cnt = 0; m_per = nxt_per; end
        else m_cnt++;
      end
      m_err = 0;
      if (wr_en && prot_en && !wr_sel) begin
        np = mod_lock ? pll : ((d >> 1) & 1);
        cand = (mod_lock || wdt_osc_lock) ? stop : (d & 1);
        ns = (cand == 1 && stop == 0 && (np == 1 || osc_det_en)) ? 0 : cand;
        m_sys = (d & 'hC0) | ((((d >> 5) & 1) | ns) << 5) | (np << 1) | ns;
      end else if (wr_en && prot_en && wr_sel) begin
        f = d & 3; pd = (d >> 2) & 3;
        if (f == 2) begin f = m_osc & 3; m_err = 1; end
        if (pd == 0) begin pd = (m_osc >> 2) & 3; m_err = 1; end
        m_osc = (pd << 2) | f;
      end
    end
    #5;
    if (rst_n) begin
      chk("R2/R5/R6/R7/R8/R12 sys_reg", sys_reg, m_sys);
      chk("R2/R9/R12 osc_reg", osc_reg, m_osc);
      chk("R9 wr_err", wr_err, m_err);
      chk("R1 stop_req", stop_req, m_sys & 1);
      chk("R1 pll_sel", pll_sel, (m_sys >> 1) & 1);
      chk("R8 drive_hi", drive_hi, (m_sys >> 5) & 1);
      chk("R3/R4/R10/R11 main_tick", main_tick,
          (m_cnt == m_per - 1 && (m_sys & 1) == 0) ? 1 : 0);
    end
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d, input logic prot = 1'b1);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; prot_en = prot;
    @(negedge clk);
    wr_en = 0; prot_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 sys_reg reset", sys_reg, 'h20);
    chk("R1 osc_reg reset", osc_reg, 'h05);
    chk("R1 wr_err reset", wr_err, 0);
    // R2 unprotected writes
    wr(0, 8'hC3, 1'b0);
    wr(1, 8'h0F, 1'b0);
    chk("R2 sys unchanged", sys_reg, 'h20);
    chk("R2 osc unchanged", osc_reg, 'h05);
    // R3 each division code, R10 mid-period changes
    for (int c = 0; c < 4; c++) begin wr(0, 8'(c << 6) | 8'h20); idle(40); end
    wr(0, 8'h40); idle(1); wr(0, 8'hC0); idle(3); wr(0, 8'h80); idle(30);
    // R4 bypass
    div_bypass = 1; idle(25); div_bypass = 0; idle(20);
    // R5 modification lock
    mod_lock = 1; wr(0, 8'h03); wr(0, 8'h82); mod_lock = 0;
    chk("R5 lock kept stop/pll", sys_reg & 3, 0);
    // R6 watchdog lock
    wdt_osc_lock = 1; wr(0, 8'h01); wdt_osc_lock = 0;
    chk("R6 stop kept", stop_req, 0);
    // R7 stop blocked under PLL select and detection
    wr(0, 8'h03);
    chk("R7 stop blocked by pll", stop_req, 0);
    wr(0, 8'h00);
    osc_det_en = 1; wr(0, 8'h01); osc_det_en = 0;
    chk("R7 stop blocked by detection", stop_req, 0);
    // R8 R11 stop entry forces drive, halts ticks
    wr(0, 8'h41); idle(20);
    chk("R8 drive forced", drive_hi, 1);
    wr(0, 8'h40); idle(20);
    // R9 reserved codes
    wr(1, 8'h0E);
    wr(1, 8'h00);
    wr(1, 8'h0B);
    chk("R9 osc fields", osc_reg, 'h0B);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en        = ($urandom_range(0, 9) < 3);
      wr_sel       = $urandom_range(0, 1);
      wr_data      = 8'($urandom);
      prot_en      = ($urandom_range(0, 9) < 7);
      div_bypass   = ($urandom_range(0, 9) == 0);
      mod_lock     = ($urandom_range(0, 9) < 2);
      wdt_osc_lock = ($urandom_range(0, 9) < 2);
      osc_det_en   = ($urandom_range(0, 9) < 2);
    end
    @(negedge clk);
    wr_en = 0;
    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule